// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two clock domains with a pair of independent first-in first-out queues running in opposite directions. The forward queue accepts words on side A (clocked by `clk_a`) and delivers them on side B (clocked by `clk_b`). The return queue accepts words on side B and delivers them on side A. Each side has one set of plain control pins: an active-low select, a direction pin, a mailbox pin and an enable. On every rising edge of its own clock these pins decide whether the side pushes into its outgoing queue, pops from its incoming queue, or does nothing.

Side A also sees two active-low threshold flags. The near-empty flag watches the return queue against a static offset `ae_level`. The near-full flag watches the forward queue against a static offset `af_level`. Both flags are evaluated in the `clk_a` domain. Each flag asserts in the same cycle as the local side-A action that crosses its threshold. It releases only after the far-side pointer has crossed a two-stage synchronizer, so the release arrives two or three `clk_a` edges after the far-side edge.

There is no valid/ready handshake. A side pushes or pops whenever its control pins qualify a cycle. Back-pressure works as follows. A push into a full queue is dropped, and a pop from an empty queue is dropped. In both cases the pointers do not move, and the read-data register keeps its last value.

Top module: `bidir_fifo_pair`

## Requirements
- R1: On a rising `clk_a` edge, the side-A controls select an action when `a_sel_n`=0, `a_mbox`=0 and `a_en`=1.
  - With `a_dir`=1, the edge pushes `a_wdata` into the forward queue.
  - With `a_dir`=0, the edge pops the return queue, and the popped word appears on `a_rdata` after that edge.
- R2: On a rising `clk_b` edge, the side-B controls select an action when `b_sel_n`=0, `b_mbox`=0 and `b_en`=1.
  - With `b_dir`=0, the edge pushes `b_wdata` into the return queue.
  - With `b_dir`=1, the edge pops the forward queue, and the popped word appears on `b_rdata` after that edge.
- R3: A side does nothing on an edge where its select is 1, its mailbox pin is 1 or its enable is 0. No word is stored, no word is removed and no pointer moves.
- R4: Each queue delivers its 36-bit words unchanged and in the order they were pushed.
- R5: A queue holds at most DEPTH words. A push while the pusher sees the queue as full is dropped, and the stored words are kept.
- R6: A pop while the popper sees the queue as empty is dropped, and that side's read-data output keeps its previous value.
- R7: `a_near_empty_n` is 0 whenever the return queue, as seen from side A, holds `ae_level` words or fewer. It goes to 0 directly after the side-A pop that brings the count down to `ae_level`.
- R8: After the side-B push that raises the return queue from `ae_level` to `ae_level`+1 words, `a_near_empty_n` stays 0 until at least two `clk_a` edges have passed. It is 1 by the third `clk_a` edge.
- R9: `a_near_full_n` is 0 whenever the forward queue holds DEPTH-`af_level` words or more. It goes to 0 directly after the side-A push that reaches that count.
- R10: After the side-B pop that lowers the forward queue from DEPTH-`af_level` to DEPTH-`af_level`-1 words, `a_near_full_n` is 1 by the third `clk_a` edge. It does not change before a second `clk_a` edge.
- R11: While the resets are held, and right after they are released:
  - both queues are empty;
  - `a_near_empty_n` is 0 and `a_near_full_n` is 1;
  - both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous reset, active low |
| a_sel_n | input | 1 | Side A select, active low |
| a_dir | input | 1 | Side A direction: 1 push forward queue, 0 pop return queue |
| a_mbox | input | 1 | Side A mailbox pin; 1 blocks queue access |
| a_en | input | 1 | Side A enable |
| a_wdata | input | DATA_W | Side A push data |
| a_rdata | output | DATA_W | Side A pop data register |
| a_near_empty_n | output | 1 | Return queue at or below `ae_level`, active low |
| a_near_full_n | output | 1 | Forward queue at or above DEPTH-`af_level`, active low |
| ae_level | input | AW | Static near-empty offset, 0 < value < DEPTH |
| af_level | input | AW | Static near-full offset, 0 < value < DEPTH |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous reset, active low |
| b_sel_n | input | 1 | Side B select, active low |
| b_dir | input | 1 | Side B direction: 0 push return queue, 1 pop forward queue |
| b_mbox | input | 1 | Side B mailbox pin; 1 blocks queue access |
| b_en | input | 1 | Side B enable |
| b_wdata | input | DATA_W | Side B push data |
| b_rdata | output | DATA_W | Side B pop data register |

## Verification
Suppose a pointer moves on a cycle that was not qualified, or an overflowing push is accepted. Either fault shows up on the very next qualified pop: a word appears out of order or a stray word appears on the read-data port. A pop from an empty queue that wrongly moves the pointer changes `a_rdata` or `b_rdata` at the next edge of that side. A wrong fill count or a broken synchronizer shows up on side A in one of two ways: a threshold flag misses its fall on the crossing edge, or it misses its release window of two to three `clk_a` edges.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  // Which direction level makes a side push into its outgoing queue.
  typedef enum logic {PUSH_ON_DIR_LOW = 1'b0, PUSH_ON_DIR_HIGH = 1'b1} push_level_e;
  localparam int DEF_DATA_W = 36;
  localparam int DEF_DEPTH  = 16;
endpackage

// File: rtl/bfp_sync.sv
module bfp_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin_out[i] = ^(stage2 >> i);
    end
  end
endmodule

// File: rtl/bfp_port_decode.sv
module bfp_port_decode #(
  parameter bfp_pkg::push_level_e PUSH_LEVEL = bfp_pkg::PUSH_ON_DIR_HIGH
) (
  input  logic sel_n,
  input  logic dir,
  input  logic mbox,
  input  logic en,
  output logic push,
  output logic pop
);
  logic active;
  assign active = !sel_n && !mbox && en;

  generate
    if (PUSH_LEVEL == bfp_pkg::PUSH_ON_DIR_HIGH) begin : g_push_high
      assign push = active && dir;
      assign pop  = active && !dir;
    end else begin : g_push_low
      assign push = active && !dir;
      assign pop  = active && dir;
    end
  endgenerate
endmodule

// File: rtl/bfp_fifo_core.sv
module bfp_fifo_core #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rdata,
  output logic [PW-1:0]     w_fill,
  output logic [PW-1:0]     r_fill,
  output logic [PW-1:0]     w_ptr,
  output logic [PW-1:0]     r_ptr,
  output logic              r_empty
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic [PW-1:0] rbin_at_w, wbin_at_r;
  logic          w_full, wr_fire, rd_fire;

  bfp_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .gray_in(rgray), .bin_out(rbin_at_w));
  bfp_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .gray_in(wgray), .bin_out(wbin_at_r));

  // Push side
  assign w_fill  = wbin - rbin_at_w;
  assign w_full  = (w_fill == FULL_CNT);
  assign wr_fire = wr_req && !w_full;
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wbin[AW-1:0]] <= wdata;
  end

  // Pop side
  assign r_fill  = wbin_at_r - rbin;
  assign r_empty = (r_fill == '0);
  assign rd_fire = rd_req && !r_empty;
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      rdata <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      rdata <= mem[rbin[AW-1:0]];
    end
  end

  assign w_ptr = wbin;
  assign r_ptr = rbin;
endmodule

// File: rtl/bidir_fifo_pair.sv
module bidir_fifo_pair #(
  parameter int DATA_W = bfp_pkg::DEF_DATA_W,
  parameter int DEPTH  = bfp_pkg::DEF_DEPTH,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              a_sel_n,
  input  logic              a_dir,
  input  logic              a_mbox,
  input  logic              a_en,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_near_empty_n,
  output logic              a_near_full_n,
  input  logic [AW-1:0]     ae_level,
  input  logic [AW-1:0]     af_level,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              b_sel_n,
  input  logic              b_dir,
  input  logic              b_mbox,
  input  logic              b_en,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic a_push_f1, a_pop_f2, b_push_f2, b_pop_f1;
  logic [PW-1:0] f1_wfill, f1_rfill, f1_wptr, f1_rptr;
  logic [PW-1:0] f2_wfill, f2_rfill, f2_wptr, f2_rptr;
  logic f1_empty, f2_empty;

  bfp_port_decode #(.PUSH_LEVEL(bfp_pkg::PUSH_ON_DIR_HIGH)) u_dec_a (
    .sel_n(a_sel_n), .dir(a_dir), .mbox(a_mbox), .en(a_en),
    .push(a_push_f1), .pop(a_pop_f2));

  bfp_port_decode #(.PUSH_LEVEL(bfp_pkg::PUSH_ON_DIR_LOW)) u_dec_b (
    .sel_n(b_sel_n), .dir(b_dir), .mbox(b_mbox), .en(b_en),
    .push(b_push_f2), .pop(b_pop_f1));

  // Forward queue: pushed on side A, popped on side B
  bfp_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fwd (
    .wclk(clk_a), .wrst_n(rst_a_n), .wr_req(a_push_f1), .wdata(a_wdata),
    .rclk(clk_b), .rrst_n(rst_b_n), .rd_req(b_pop_f1), .rdata(b_rdata),
    .w_fill(f1_wfill), .r_fill(f1_rfill), .w_ptr(f1_wptr), .r_ptr(f1_rptr),
    .r_empty(f1_empty));

  // Return queue: pushed on side B, popped on side A
  bfp_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ret (
    .wclk(clk_b), .wrst_n(rst_b_n), .wr_req(b_push_f2), .wdata(b_wdata),
    .rclk(clk_a), .rrst_n(rst_a_n), .rd_req(a_pop_f2), .rdata(a_rdata),
    .w_fill(f2_wfill), .r_fill(f2_rfill), .w_ptr(f2_wptr), .r_ptr(f2_rptr),
    .r_empty(f2_empty));

  // Side-A threshold flags from the local pointer and the synchronized far pointer
  assign a_near_empty_n = (f2_rfill > {1'b0, ae_level});
  assign a_near_full_n  = (f1_wfill < (FULL_CNT - {1'b0, af_level}));
endmodule

// File: rtl/bfp_checker.sv
module bfp_checker #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 16,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic              clk_a,
  input logic              rst_a_n,
  input logic              clk_b,
  input logic              rst_b_n,
  input logic              a_sel_n,
  input logic              a_mbox,
  input logic              a_en,
  input logic              a_pop_req,
  input logic              b_pop_req,
  input logic [DATA_W-1:0] a_rdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic              near_empty_n,
  input logic              near_full_n,
  input logic [PW-1:0]     f1_wfill,
  input logic [PW-1:0]     f1_rfill,
  input logic [PW-1:0]     f1_wptr,
  input logic              f1_empty,
  input logic [PW-1:0]     f2_wfill,
  input logic [PW-1:0]     f2_rptr,
  input logic              f2_empty
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  // R3: an unqualified side-A edge moves neither side-A pointer
  p_idle_a_r3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_sel_n || a_mbox || !a_en) |=> ($stable(f1_wptr) && $stable(f2_rptr)));

  // R5: fill seen by the pusher never exceeds DEPTH
  p_no_overflow_r5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    f1_wfill <= FULL_CNT);
  p_no_overflow_ret_r5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    f2_wfill <= FULL_CNT);
  p_fill_bound_r5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    f1_rfill <= FULL_CNT);

  // R6: a pop on an empty queue leaves the read data alone
  p_empty_pop_a_r6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_pop_req && f2_empty) |=> $stable(a_rdata));
  p_empty_pop_b_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_pop_req && f1_empty) |=> $stable(b_rdata));

  // R7: the near-empty flag only falls on a side-A pop
  p_ae_fall_r7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $fell(near_empty_n) |-> (f2_rptr != $past(f2_rptr)));

  // R9: the near-full flag only falls on a side-A push
  p_af_fall_r9: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $fell(near_full_n) |-> (f1_wptr != $past(f1_wptr)));
endmodule

bind bidir_fifo_pair bfp_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
  .a_sel_n(a_sel_n), .a_mbox(a_mbox), .a_en(a_en),
  .a_pop_req(a_pop_f2), .b_pop_req(b_pop_f1),
  .a_rdata(a_rdata), .b_rdata(b_rdata),
  .near_empty_n(a_near_empty_n), .near_full_n(a_near_full_n),
  .f1_wfill(f1_wfill), .f1_rfill(f1_rfill), .f1_wptr(f1_wptr), .f1_empty(f1_empty),
  .f2_wfill(f2_wfill), .f2_rptr(f2_rptr), .f2_empty(f2_empty));

// File: tb/tb_bidir_fifo_pair.sv
`timescale 1ns/1ps
module tb_bidir_fifo_pair;
  localparam int DW = 36;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam int X2 = 3;
  localparam int Y1 = 4;

  logic clk_a = 0, clk_b = 0, rst_a_n = 0, rst_b_n = 0;
  logic a_sel_n = 1, a_dir = 0, a_mbox = 0, a_en = 0;
  logic b_sel_n = 1, b_dir = 0, b_mbox = 0, b_en = 0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_near_empty_n, a_near_full_n;
  logic [AW-1:0] ae_level = AW'(X2);
  logic [AW-1:0] af_level = AW'(Y1);

  always #10   clk_a = ~clk_a;   // 50 MHz
  always #13.7 clk_b = ~clk_b;   // unrelated

  bidir_fifo_pair #(.DATA_W(DW), .DEPTH(D)) dut (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_sel_n(a_sel_n), .a_dir(a_dir),
    .a_mbox(a_mbox), .a_en(a_en), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_near_empty_n(a_near_empty_n), .a_near_full_n(a_near_full_n),
    .ae_level(ae_level), .af_level(af_level),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_sel_n(b_sel_n), .b_dir(b_dir),
    .b_mbox(b_mbox), .b_en(b_en), .b_wdata(b_wdata), .b_rdata(b_rdata));

  int n_cmp = 0, n_bad = 0;
  bit mon_on = 0, done = 0;
  logic [DW-1:0] q1 [$];
  logic [DW-1:0] q2 [$];
  logic [DW-1:0] ra_exp = '0, rb_exp = '0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    return {4'hA, 32'(k * 32'h9E37_79B9 + 32'h1234)};
  endfunction

  // Cycle-by-cycle reference comparison of both read-data registers (R4)
  always @(negedge clk_a) if (mon_on) check("R4 a_rdata per-cycle", a_rdata, ra_exp);
  always @(negedge clk_b) if (mon_on) check("R4 b_rdata per-cycle", b_rdata, rb_exp);

  task automatic a_cycle(input logic sel_n, input logic mbox, input logic en,
                         input logic dir, input logic [DW-1:0] d);
    @(negedge clk_a);
    a_sel_n = sel_n; a_mbox = mbox; a_en = en; a_dir = dir; a_wdata = d;
    @(posedge clk_a); #1;
    if (!sel_n && !mbox && en) begin
      if (dir) begin
        if (q1.size() < D) q1.push_back(d);
      end else if (q2.size() > 0) ra_exp = q2.pop_front();
    end
    a_sel_n = 1; a_en = 0; a_mbox = 0;
    @(negedge clk_a);
  endtask

  task automatic b_cycle(input logic sel_n, input logic mbox, input logic en,
                         input logic dir, input logic [DW-1:0] d);
    @(negedge clk_b);
    b_sel_n = sel_n; b_mbox = mbox; b_en = en; b_dir = dir; b_wdata = d;
    @(posedge clk_b); #1;
    if (!sel_n && !mbox && en) begin
      if (!dir) begin
        if (q2.size() < D) q2.push_back(d);
      end else if (q1.size() > 0) rb_exp = q1.pop_front();
    end
    b_sel_n = 1; b_en = 0; b_mbox = 0;
    @(negedge clk_b);
  endtask

  task automatic a_wr(input logic [DW-1:0] d); a_cycle(0, 0, 1, 1, d); endtask
  task automatic a_rd();                       a_cycle(0, 0, 1, 0, '0); endtask
  task automatic b_wr(input logic [DW-1:0] d); b_cycle(0, 0, 1, 0, d); endtask
  task automatic b_rd();                       b_cycle(0, 0, 1, 1, '0); endtask

  task automatic settle();
    repeat (4) @(posedge clk_a);
    repeat (4) @(posedge clk_b);
    @(negedge clk_a);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_a);
    #2;
    // R11: reset state
    check("R11 near_empty_n in reset", a_near_empty_n, 0);
    check("R11 near_full_n in reset", a_near_full_n, 1);
    rst_a_n = 1; rst_b_n = 1;
    settle();
    check("R11 near_empty_n after reset", a_near_empty_n, 0);
    check("R11 near_full_n after reset", a_near_full_n, 1);
    check("R11 a_rdata after reset", a_rdata, 0);
    check("R11 b_rdata after reset", b_rdata, 0);
    mon_on = 1;

    // R3: unqualified side-A cycles store nothing; R1/R2 then one real word
    a_cycle(1, 0, 1, 1, 36'hBAD_0001);
    a_cycle(0, 1, 1, 1, 36'hBAD_0002);
    a_cycle(0, 0, 0, 1, 36'hBAD_0003);
    a_wr(36'h111_2222);
    settle();
    b_rd();
    check("R1 R2 R3 first forward word", b_rdata, 36'h111_2222);
    b_rd();                                   // R6: queue now empty
    check("R6 empty pop on side B holds data", b_rdata, 36'h111_2222);
    // R3 on side B: unqualified cycles must not push into the return queue
    b_cycle(1, 0, 1, 0, 36'hBAD_0004);
    b_cycle(0, 1, 1, 0, 36'hBAD_0005);
    b_cycle(0, 0, 0, 0, 36'hBAD_0006);
    settle();
    a_rd();
    check("R3 R6 side-A pop after ignored pushes", a_rdata, 0);

    // R4: order in both directions
    for (int k = 0; k < 10; k++) a_wr(pat(k));
    settle();
    for (int k = 0; k < 10; k++) begin
      b_rd();
      check("R4 forward order", b_rdata, pat(k));
    end
    for (int k = 0; k < 7; k++) b_wr(pat(100 + k));
    settle();
    for (int k = 0; k < 7; k++) begin
      a_rd();
      check("R2 R4 return order", a_rdata, pat(100 + k));
    end
    a_rd();
    check("R6 empty pop on side A holds data", a_rdata, pat(106));

    // R7 / R8: near-empty on the return queue
    for (int k = 0; k < X2; k++) b_wr(pat(200 + k));
    settle();
    check("R7 near_empty_n at X2 words", a_near_empty_n, 0);
    b_wr(pat(200 + X2));
    check("R8 near_empty_n not early", a_near_empty_n, 0);
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    check("R8 near_empty_n released", a_near_empty_n, 1);
    settle();
    a_rd();
    check("R7 near_empty_n falls on pop", a_near_empty_n, 0);
    check("R4 return word during flag test", a_rdata, pat(200));
    for (int k = 1; k <= X2; k++) a_rd();
    check("R4 last return word", a_rdata, pat(200 + X2));

    // R9 / R10: near-full on the forward queue
    for (int k = 0; k < D - Y1 - 1; k++) a_wr(pat(300 + k));
    settle();
    check("R9 near_full_n below threshold", a_near_full_n, 1);
    a_wr(pat(300 + D - Y1 - 1));
    check("R9 near_full_n falls on push", a_near_full_n, 0);
    settle();
    b_rd();
    check("R10 near_full_n not early", a_near_full_n, 0);
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    check("R10 near_full_n released", a_near_full_n, 1);
    settle();

    // R5: fill to DEPTH, then two pushes that must be dropped
    for (int k = q1.size(); k < D; k++) a_wr(pat(400 + k));
    a_wr(36'hBAD_00F1);
    a_wr(36'hBAD_00F2);
    check("R9 near_full_n low when full", a_near_full_n, 0);
    check("R5 model holds DEPTH", 36'(q1.size()), 36'(D));
    settle();
    for (int k = 0; k < D + 1; k++) b_rd();
    check("R5 R6 last forward word kept", b_rdata, pat(400 + D - 1));
    settle();
    check("R10 near_full_n after drain", a_near_full_n, 1);

    repeat (4) @(negedge clk_a);
    finish_run();
  end
endmodule